// File: doc/BRIEF.md
# Processor Trace Status Encoder

This block turns per-cycle execution events from a processor core into a 4-bit trace status code and a 4-bit trace data stream. An external capture probe uses these two buses to rebuild the program flow. A taken branch shows the branch code for one cycle. When the branch target was computed at run time, the block also sends part of the target address. Such targets come from returns, register-indirect or indexed jumps and calls, and exception vectors. First it shows a marker code that gives the byte count. Then it sends the address one nibble per cycle on the data bus.

Long-lasting core states are shown as status codes that stay on the bus for as long as the state lasts. These states are halted, stopped, emulator-mode entry and exception processing. They take priority over the branch and marker codes. A two-bit control field chooses how many address bytes are sent after a computed-target branch. The value 0 turns address output off.

Top module: `trace_status_enc`

## Requirements
- R1: While reset is asserted and right after it, `pst_o` is 0x0 and `ddata_o` is 0x0.
- R2: A taken branch sampled at a clock edge makes `pst_o` equal 0x5 for the following cycle, unless a held status code is active. A branch without a computed target produces no marker and no address data.
- R3: A computed-target taken branch with `addr_bytes_sel_i` non-zero is followed one cycle after the 0x5 by a marker on `pst_o`. The marker is 0x9 for selector 1 (2 bytes), 0xA for selector 2 (3 bytes) and 0xB for selector 3 (4 bytes).
- R4: In the cycle after the marker, `ddata_o` starts sending the captured target, one nibble per cycle. The least significant byte goes first, and within each byte the low nibble goes before the high nibble. After twice the byte count of nibbles, `ddata_o` returns to 0x0.
- R5: When `addr_bytes_sel_i` is 0, a computed-target branch produces only 0x5. No marker follows, and `ddata_o` stays 0x0.
- R6: A new computed-target branch that arrives while an earlier address is still being sent discards the remaining nibbles. `ddata_o` reads 0x0 in the cycle that shows the new 0x5, and a fresh marker and the new address follow.
- R7: While `exc_active_i` is high, with no higher condition active, `pst_o` reads 0xC in every following cycle.
- R8: While `emu_entry_i` is high, `pst_o` reads 0xD and wins over exception processing.
- R9: While `stopped_i` is high, `pst_o` reads 0xE. While `halted_i` is high, `pst_o` reads 0xF. Halted wins over every other code, and stopped wins over all except halted.
- R10: A pending marker waits while a held code or a taken branch occupies the status slot. No address nibble is sent until the marker has appeared, so `ddata_o` stays 0x0 while the marker waits.
- R11: With no condition, branch or marker to report, `pst_o` reads 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_taken_i | input | 1 | A taken branch completed this cycle |
| br_variant_i | input | 1 | The taken branch used a computed target |
| br_target_i | input | 32 | Target address of the branch |
| addr_bytes_sel_i | input | 2 | Address bytes to send: 0 off, 1 two, 2 three, 3 four |
| exc_active_i | input | 1 | Exception processing in progress |
| emu_entry_i | input | 1 | Exception that enters emulator mode in progress |
| stopped_i | input | 1 | Core stopped, waiting for an interrupt |
| halted_i | input | 1 | Core halted |
| pst_o | output | 4 | Registered trace status code |
| ddata_o | output | 4 | Registered trace data nibble |

## Verification
Both outputs are registered, so every code reflects the inputs sampled at the previous clock edge. The 0x5 or a held code appears one cycle after its input, and a marker appears one cycle after the 0x5 if the status slot is free. Nibble k of the address appears k+1 cycles after the marker. The bench drives inputs on the falling edge and steps one rising edge at a time. After each step it samples both buses on the next falling edge and compares them with a sequence computed from the target, the selector and the override pattern of that scenario.

// File: rtl/tse_pkg.sv
package tse_pkg;

    typedef enum logic [3:0] {
        PST_IDLE   = 4'h0,
        PST_BRANCH = 4'h5,
        PST_MARK2  = 4'h9,
        PST_MARK3  = 4'hA,
        PST_MARK4  = 4'hB,
        PST_EXC    = 4'hC,
        PST_EMU    = 4'hD,
        PST_STOP   = 4'hE,
        PST_HALT   = 4'hF
    } pst_code_e;

    typedef struct packed {
        logic [3:0] pst;
        logic [3:0] ddata;
    } trace_out_t;

endpackage

// File: rtl/tse_status_arb.sv
module tse_status_arb
    import tse_pkg::*;
(
    input  logic      halted_i,
    input  logic      stopped_i,
    input  logic      emu_entry_i,
    input  logic      exc_active_i,
    input  logic      br_taken_i,
    input  logic      mark_pend_i,
    input  pst_code_e mark_code_i,
    output pst_code_e pst_next_o,
    output logic      marker_fire_o
);

    logic held_active;

    always_comb begin
        held_active   = halted_i | stopped_i | emu_entry_i | exc_active_i;
        marker_fire_o = 1'b0;
        pst_next_o    = PST_IDLE;
        if (halted_i) begin
            pst_next_o = PST_HALT;
        end else if (stopped_i) begin
            pst_next_o = PST_STOP;
        end else if (emu_entry_i) begin
            pst_next_o = PST_EMU;
        end else if (exc_active_i) begin
            pst_next_o = PST_EXC;
        end else if (br_taken_i) begin
            pst_next_o = PST_BRANCH;
        end else if (mark_pend_i) begin
            pst_next_o    = mark_code_i;
            marker_fire_o = 1'b1;
        end
        if (held_active) begin
            marker_fire_o = 1'b0;
        end
    end

endmodule

// File: rtl/tse_addr_stream.sv
module tse_addr_stream
    import tse_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [1:0]        bytes_sel_i,
    input  logic              marker_fire_i,
    output logic              mark_pend_o,
    output pst_code_e         mark_code_o,
    output logic              nib_valid_o,
    output logic [NIB_W-1:0]  nib_o
);

    localparam int NIB_N     = ADDR_W / NIB_W;
    localparam int CNT_W     = $clog2(NIB_N + 1);
    localparam int BYTE_NIBS = 8 / NIB_W;

    typedef struct packed {
        logic [ADDR_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              pend;
        pst_code_e         code;
    } stream_t;

    stream_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.shreg = target_i;
            s_d.cnt   = CNT_W'((int'(bytes_sel_i) + 1) * BYTE_NIBS);
            s_d.pend  = 1'b1;
            case (bytes_sel_i)
                2'd1:    s_d.code = PST_MARK2;
                2'd2:    s_d.code = PST_MARK3;
                default: s_d.code = PST_MARK4;
            endcase
        end else if (s_q.pend) begin
            if (marker_fire_i) begin
                s_d.pend = 1'b0;
            end
        end else if (s_q.cnt != '0) begin
            s_d.shreg = s_q.shreg >> NIB_W;
            s_d.cnt   = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{shreg: '0, cnt: '0, pend: 1'b0, code: PST_IDLE};
        end else begin
            s_q <= s_d;
        end
    end

    assign mark_pend_o = s_q.pend;
    assign mark_code_o = s_q.code;
    assign nib_valid_o = !s_q.pend && (s_q.cnt != '0);
    assign nib_o       = s_q.shreg[NIB_W-1:0];

endmodule

// File: rtl/trace_status_enc.sv
module trace_status_enc
    import tse_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_taken_i,
    input  logic              br_variant_i,
    input  logic [ADDR_W-1:0] br_target_i,
    input  logic [1:0]        addr_bytes_sel_i,
    input  logic              exc_active_i,
    input  logic              emu_entry_i,
    input  logic              stopped_i,
    input  logic              halted_i,
    output logic [3:0]        pst_o,
    output logic [NIB_W-1:0]  ddata_o
);

    logic             load_w;
    logic             mark_pend_w;
    pst_code_e        mark_code_w;
    logic             marker_fire_w;
    logic             nib_valid_w;
    logic [NIB_W-1:0] nib_w;
    pst_code_e        pst_next_w;

    logic [3:0]       pst_d, pst_q;
    logic [NIB_W-1:0] ddata_d, ddata_q;

    assign load_w = br_taken_i && br_variant_i && (addr_bytes_sel_i != 2'd0);

    tse_status_arb u_arb (
        .halted_i      (halted_i),
        .stopped_i     (stopped_i),
        .emu_entry_i   (emu_entry_i),
        .exc_active_i  (exc_active_i),
        .br_taken_i    (br_taken_i),
        .mark_pend_i   (mark_pend_w),
        .mark_code_i   (mark_code_w),
        .pst_next_o    (pst_next_w),
        .marker_fire_o (marker_fire_w)
    );

    tse_addr_stream #(
        .ADDR_W (ADDR_W),
        .NIB_W  (NIB_W)
    ) u_stream (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (load_w),
        .target_i      (br_target_i),
        .bytes_sel_i   (addr_bytes_sel_i),
        .marker_fire_i (marker_fire_w),
        .mark_pend_o   (mark_pend_w),
        .mark_code_o   (mark_code_w),
        .nib_valid_o   (nib_valid_w),
        .nib_o         (nib_w)
    );

    always_comb begin
        pst_d   = pst_next_w;
        ddata_d = (nib_valid_w && !load_w) ? nib_w : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pst_q   <= PST_IDLE;
            ddata_q <= '0;
        end else begin
            pst_q   <= pst_d;
            ddata_q <= ddata_d;
        end
    end

    assign pst_o   = pst_q;
    assign ddata_o = ddata_q;

endmodule

// File: rtl/tse_checker.sv
module tse_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       br_taken_i,
    input logic       exc_active_i,
    input logic       emu_entry_i,
    input logic       stopped_i,
    input logic       halted_i,
    input logic       mark_pend,
    input logic [3:0] pst_o,
    input logic [3:0] ddata_o
);

    p_branch_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken_i && !halted_i && !stopped_i && !emu_entry_i && !exc_active_i)
        |=> pst_o == 4'h5);

    p_exc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_active_i && !halted_i && !stopped_i && !emu_entry_i) |=> pst_o == 4'hC);

    p_emu_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (emu_entry_i && !halted_i && !stopped_i) |=> pst_o == 4'hD);

    p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped_i && !halted_i) |=> pst_o == 4'hE);

    p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted_i |=> pst_o == 4'hF);

    p_quiet_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mark_pend |=> ddata_o == 4'h0);

    p_idle_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_taken_i && !halted_i && !stopped_i && !emu_entry_i && !exc_active_i && !mark_pend)
        |=> pst_o == 4'h0);

endmodule

bind trace_status_enc tse_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_taken_i   (br_taken_i),
    .exc_active_i (exc_active_i),
    .emu_entry_i  (emu_entry_i),
    .stopped_i    (stopped_i),
    .halted_i     (halted_i),
    .mark_pend    (mark_pend_w),
    .pst_o        (pst_o),
    .ddata_o      (ddata_o)
);

// File: tb/trace_status_enc_tb.sv
module trace_status_enc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_taken_i = 1'b0;
    logic        br_variant_i = 1'b0;
    logic [31:0] br_target_i = '0;
    logic [1:0]  addr_bytes_sel_i = 2'd0;
    logic        exc_active_i = 1'b0;
    logic        emu_entry_i = 1'b0;
    logic        stopped_i = 1'b0;
    logic        halted_i = 1'b0;
    logic [3:0]  pst_o;
    logic [3:0]  ddata_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trace_status_enc u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .br_taken_i       (br_taken_i),
        .br_variant_i     (br_variant_i),
        .br_target_i      (br_target_i),
        .addr_bytes_sel_i (addr_bytes_sel_i),
        .exc_active_i     (exc_active_i),
        .emu_entry_i      (emu_entry_i),
        .stopped_i        (stopped_i),
        .halted_i         (halted_i),
        .pst_o            (pst_o),
        .ddata_o          (ddata_o)
    );

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%h expected 0x%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        br_taken_i   = 1'b0;
        br_variant_i = 1'b0;
        exc_active_i = 1'b0;
        emu_entry_i  = 1'b0;
        stopped_i    = 1'b0;
        halted_i     = 1'b0;
    endtask

    task automatic fire_branch(input logic variant, input logic [31:0] tgt, input logic [1:0] sel);
        br_taken_i       = 1'b1;
        br_variant_i     = variant;
        br_target_i      = tgt;
        addr_bytes_sel_i = sel;
        step();
        clear_inputs();
    endtask

    task automatic expect_stream(input logic [31:0] tgt, input logic [1:0] sel, input string req);
        int nibs;
        nibs = (int'(sel) + 1) * 2;
        chk(pst_o, 4'h8 + 4'(sel), "R3", "marker code");
        chk(ddata_o, 4'h0, "R10", "no data with marker");
        for (int i = 0; i < nibs; i++) begin
            step();
            chk(ddata_o, 4'((tgt >> (4 * i)) & 32'hF), req, $sformatf("nibble %0d", i));
        end
        step();
        chk(ddata_o, 4'h0, "R4", "data bus idle after stream");
        chk(pst_o, 4'h0, "R11", "status idle after stream");
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(pst_o, 4'h0, "R1", "pst in reset");
        chk(ddata_o, 4'h0, "R1", "ddata in reset");
        rst_n = 1'b1;
        step();
        chk(pst_o, 4'h0, "R1", "pst after reset");
        chk(ddata_o, 4'h0, "R1", "ddata after reset");
    endtask

    task automatic t_plain_branch();
        fire_branch(1'b0, 32'hDEAD_BEEF, 2'd3);
        chk(pst_o, 4'h5, "R2", "plain branch code");
        step();
        chk(pst_o, 4'h0, "R2", "no marker after plain branch");
        chk(ddata_o, 4'h0, "R2", "no data after plain branch");
    endtask

    task automatic t_stream(input logic [31:0] tgt, input logic [1:0] sel);
        fire_branch(1'b1, tgt, sel);
        chk(pst_o, 4'h5, "R2", "computed branch code");
        chk(ddata_o, 4'h0, "R4", "no data with branch code");
        step();
        expect_stream(tgt, sel, "R4");
    endtask

    task automatic t_disabled();
        fire_branch(1'b1, 32'h1357_9BDF, 2'd0);
        chk(pst_o, 4'h5, "R5", "branch code with output off");
        for (int i = 0; i < 4; i++) begin
            step();
            chk(pst_o, 4'h0, "R5", "no marker with output off");
            chk(ddata_o, 4'h0, "R5", "no data with output off");
        end
    endtask

    task automatic t_overwrite();
        fire_branch(1'b1, 32'h89AB_CDEF, 2'd3);
        step();
        chk(pst_o, 4'hB, "R6", "first marker");
        step();
        chk(ddata_o, 4'hF, "R6", "first nibble of old address");
        step();
        chk(ddata_o, 4'hE, "R6", "second nibble of old address");
        fire_branch(1'b1, 32'h1234_5678, 2'd1);
        chk(pst_o, 4'h5, "R6", "new branch code");
        chk(ddata_o, 4'h0, "R6", "old nibbles discarded");
        step();
        expect_stream(32'h1234_5678, 2'd1, "R6");
    endtask

    task automatic t_deferred_marker();
        fire_branch(1'b1, 32'h00C0_FFEE, 2'd2);
        chk(pst_o, 4'h5, "R10", "branch before hold");
        exc_active_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk(pst_o, 4'hC, "R7", "exception code held");
            chk(ddata_o, 4'h0, "R10", "data waits for marker");
        end
        exc_active_i = 1'b0;
        br_taken_i   = 1'b1;
        step();
        br_taken_i   = 1'b0;
        chk(pst_o, 4'h5, "R10", "plain branch takes slot");
        chk(ddata_o, 4'h0, "R10", "data still waits");
        step();
        expect_stream(32'h00C0_FFEE, 2'd2, "R10");
    endtask

    task automatic t_priority();
        halted_i = 1'b1; stopped_i = 1'b1; emu_entry_i = 1'b1; exc_active_i = 1'b1;
        br_taken_i = 1'b1;
        step();
        br_taken_i = 1'b0;
        chk(pst_o, 4'hF, "R9", "halt wins over all");
        step();
        chk(pst_o, 4'hF, "R9", "halt held");
        halted_i = 1'b0;
        step();
        chk(pst_o, 4'hE, "R9", "stop wins below halt");
        stopped_i = 1'b0;
        step();
        chk(pst_o, 4'hD, "R8", "emulator entry over exception");
        step();
        chk(pst_o, 4'hD, "R8", "emulator entry held");
        emu_entry_i = 1'b0;
        step();
        chk(pst_o, 4'hC, "R7", "exception code");
        exc_active_i = 1'b0;
        step();
        chk(pst_o, 4'h0, "R11", "idle after holds released");
        chk(ddata_o, 4'h0, "R11", "data idle after holds released");
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_plain_branch();
        t_stream(32'h89AB_CDEF, 2'd3);
        t_stream(32'h1234_5678, 2'd1);
        t_stream(32'h00C0_FFEE, 2'd2);
        t_disabled();
        t_overwrite();
        t_deferred_marker();
        t_priority();
        done = 1'b1;
        report();
        $finish;
    end

endmodule